// File: doc/BRIEF.md
# Operand Hazard Interlock and Bypass Control

This unit sits beside the decode stage of a five-stage in-order integer pipeline and decides, every cycle, where each ALU operand of the decoding instruction comes from and whether that instruction may advance. It compares the two decode-stage source register numbers against the destination, write enable and valid bit of the execute, memory and write-back pipeline registers, and drives one forwarding select per operand that names the nearest producer still in flight.

Two situations cannot be covered by forwarding alone. When the instruction in execute is a load whose destination is needed by the decoding instruction, the unit freezes fetch and decode for that cycle and turns the execute slot into a no-op. The same happens when decode reads the multiply/divide result registers while the autonomous multiply/divide unit reports busy. One load-use pattern is exempt from stalling: a store whose data operand is the loaded register. For it the unit arms a store-data bypass that is raised two cycles later, when the store sits in the memory stage and the load result is at write-back. A parameter selects whether the write-back stage is a forwarding source or is left to a register file that writes early and reads late in the cycle.

Top module: `operand_hazard_unit`

## Requirements
- R1: An operand select is nonzero only when its source number equals the destination of an execute, memory or write-back entry whose valid bit and write enable are both 1.
- R2: Select encoding is 2'b00 register file, 2'b01 execute result, 2'b10 memory result, 2'b11 write-back result; with several matches the nearest stage wins, execute over memory over write-back.
- R3: Source register 0 always yields select 2'b00 and never causes a stall, even when a stage names register 0 as its destination.
- R4: An entry whose valid bit is 0 takes part in no comparison, whatever its destination and write enable.
- R5: When decode is valid and the execute entry is a valid, writing load whose destination (nonzero) equals source A, or equals source B of a non-store, `freeze_front` and `bubble_ex` are 1 in that same cycle.
- R6: A valid store whose source B matches a load in execute causes no stall on that account, and `mem_store_bypass` is 1 exactly two clock edges later, for one cycle.
- R7: If that store is stalled in the same cycle (source A also hits the load, or a busy result-register read), no bypass is armed and `mem_store_bypass` stays 0 two edges later.
- R8: A decode read of the multiply/divide result registers (`dec_reads_hilo`=1) stalls while `muldiv_busy` is 1 and is not held by it when `muldiv_busy` is 0.
- R9: With `dec_valid`=0 no stall is raised; `freeze_front` and `bubble_ex` are equal in every cycle.
- R10: With `WB_BYPASS`=0 a match found only at write-back yields select 2'b00; execute and memory matches behave as in R2.
- R11: While reset is low and in the first cycle after it, `mem_store_bypass` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode holds a real instruction |
| dec_src_a | input | REG_ADDR_W | First source register number |
| dec_src_b | input | REG_ADDR_W | Second source register number (store data for stores) |
| dec_is_store | input | 1 | Decode instruction is a store |
| dec_reads_hilo | input | 1 | Decode instruction reads a multiply/divide result register |
| ex_valid | input | 1 | Execute entry valid |
| ex_dst | input | REG_ADDR_W | Execute destination register |
| ex_wen | input | 1 | Execute entry writes a register |
| ex_is_load | input | 1 | Execute entry is a load |
| mem_valid | input | 1 | Memory entry valid |
| mem_dst | input | REG_ADDR_W | Memory destination register |
| mem_wen | input | 1 | Memory entry writes a register |
| wb_valid | input | 1 | Write-back entry valid |
| wb_dst | input | REG_ADDR_W | Write-back destination register |
| wb_wen | input | 1 | Write-back entry writes a register |
| muldiv_busy | input | 1 | Multiply/divide unit still running |
| fwd_sel_a | output | 2 | Operand A source select |
| fwd_sel_b | output | 2 | Operand B source select |
| mem_store_bypass | output | 1 | Replace memory-stage store data with the write-back load result |
| freeze_front | output | 1 | Hold fetch and decode registers |
| bubble_ex | output | 1 | Load a no-op into the execute stage |

## Verification
The forwarding choice and the load-use decision fall in the same cycle whenever the execute entry is a load matching a source: the select still points at execute while the stall is raised, and for a store the stall is withheld and a bypass is armed instead. Random vectors over a four-register space make such coincidences frequent, and directed cases place a store whose address and data both hit the load, or a result-register read under a busy multiply/divide, in the same cycle as the store-bypass pattern. Each cycle the bench compares both selects, the stall pair and the registered bypass against a model that follows the requirements, with a second instance built without the write-back path.

// File: rtl/ohu_pkg.sv
package ohu_pkg;

    typedef enum logic [1:0] {
        SEL_RF  = 2'b00,
        SEL_EX  = 2'b01,
        SEL_MEM = 2'b10,
        SEL_WB  = 2'b11
    } fwd_sel_e;

    // Store-data bypass flag travelling with a store from execute to memory.
    typedef struct packed {
        logic in_ex;
        logic in_mem;
    } store_track_s;

endpackage

// File: rtl/ohu_src_forward.sv
module ohu_src_forward
    import ohu_pkg::*;
#(
    parameter int REG_ADDR_W = 5,
    parameter bit WB_BYPASS  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [REG_ADDR_W-1:0] src,
    input  logic                  ex_live,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  mem_live,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  wb_live,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    output fwd_sel_e              sel,
    output logic                  hit_ex
);

    logic src_real;
    logic hit_mem;
    logic hit_wb;

    always_comb begin
        src_real = (src != '0);
        hit_ex   = src_real && ex_live  && (ex_dst  == src);
        hit_mem  = src_real && mem_live && (mem_dst == src);
    end

    generate
        if (WB_BYPASS) begin : g_wb_path
            always_comb hit_wb = src_real && wb_live && (wb_dst == src);
        end else begin : g_wb_none
            always_comb hit_wb = 1'b0;

            p_no_wb_select_r10: assert property (@(posedge clk) disable iff (!rst_n)
                sel != SEL_WB);
        end
    endgenerate

    always_comb begin
        if (hit_ex)       sel = SEL_EX;
        else if (hit_mem) sel = SEL_MEM;
        else if (hit_wb)  sel = SEL_WB;
        else              sel = SEL_RF;
    end

    p_zero_source_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (src == '0) |-> (sel == SEL_RF && !hit_ex));

    p_live_ex_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_live && ex_dst == src && src != '0) |-> (sel == SEL_EX));

endmodule

// File: rtl/ohu_interlock.sv
module ohu_interlock (
    input  logic clk,
    input  logic rst_n,
    input  logic dec_valid,
    input  logic dec_is_store,
    input  logic dec_reads_hilo,
    input  logic muldiv_busy,
    input  logic ex_load_live,
    input  logic a_hit_ex,
    input  logic b_hit_ex,
    output logic stall,
    output logic store_arm
);

    logic use_a;
    logic use_b;
    logic hilo_wait;

    always_comb begin
        use_a     = a_hit_ex && ex_load_live;
        // store data reaches memory one stage later, so it is bypassed there
        use_b     = b_hit_ex && ex_load_live && !dec_is_store;
        hilo_wait = dec_reads_hilo && muldiv_busy;
        stall     = dec_valid && (use_a || use_b || hilo_wait);
        store_arm = dec_valid && dec_is_store && b_hit_ex && ex_load_live;
    end

    p_hilo_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && dec_reads_hilo && muldiv_busy) |-> stall);

    p_idle_decode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> !stall);

endmodule

// File: rtl/operand_hazard_unit.sv
module operand_hazard_unit
    import ohu_pkg::*;
#(
    parameter int REG_ADDR_W = 5,
    parameter bit WB_BYPASS  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  dec_valid,
    input  logic [REG_ADDR_W-1:0] dec_src_a,
    input  logic [REG_ADDR_W-1:0] dec_src_b,
    input  logic                  dec_is_store,
    input  logic                  dec_reads_hilo,
    input  logic                  ex_valid,
    input  logic [REG_ADDR_W-1:0] ex_dst,
    input  logic                  ex_wen,
    input  logic                  ex_is_load,
    input  logic                  mem_valid,
    input  logic [REG_ADDR_W-1:0] mem_dst,
    input  logic                  mem_wen,
    input  logic                  wb_valid,
    input  logic [REG_ADDR_W-1:0] wb_dst,
    input  logic                  wb_wen,
    input  logic                  muldiv_busy,
    output logic [1:0]            fwd_sel_a,
    output logic [1:0]            fwd_sel_b,
    output logic                  mem_store_bypass,
    output logic                  freeze_front,
    output logic                  bubble_ex
);

    localparam int NUM_SRC = 2;

    logic                  ex_live;
    logic                  mem_live;
    logic                  wb_live;
    logic                  ex_load_live;
    logic [REG_ADDR_W-1:0] src_vec [NUM_SRC];
    fwd_sel_e              sel_vec [NUM_SRC];
    logic [NUM_SRC-1:0]    hit_ex_vec;
    logic                  stall;
    logic                  store_arm;
    store_track_s          trk_d;
    store_track_s          trk_q;

    always_comb begin
        ex_live      = ex_valid  && ex_wen;
        mem_live     = mem_valid && mem_wen;
        wb_live      = wb_valid  && wb_wen;
        ex_load_live = ex_live   && ex_is_load;
        src_vec[0]   = dec_src_a;
        src_vec[1]   = dec_src_b;
    end

    generate
        for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
            ohu_src_forward #(
                .REG_ADDR_W (REG_ADDR_W),
                .WB_BYPASS  (WB_BYPASS)
            ) u_fwd (
                .clk      (clk),
                .rst_n    (rst_n),
                .src      (src_vec[g]),
                .ex_live  (ex_live),
                .ex_dst   (ex_dst),
                .mem_live (mem_live),
                .mem_dst  (mem_dst),
                .wb_live  (wb_live),
                .wb_dst   (wb_dst),
                .sel      (sel_vec[g]),
                .hit_ex   (hit_ex_vec[g])
            );
        end
    endgenerate

    ohu_interlock u_lock (
        .clk            (clk),
        .rst_n          (rst_n),
        .dec_valid      (dec_valid),
        .dec_is_store   (dec_is_store),
        .dec_reads_hilo (dec_reads_hilo),
        .muldiv_busy    (muldiv_busy),
        .ex_load_live   (ex_load_live),
        .a_hit_ex       (hit_ex_vec[0]),
        .b_hit_ex       (hit_ex_vec[1]),
        .stall          (stall),
        .store_arm      (store_arm)
    );

    // Next-state: a bubble in execute drops the flag; execute always moves to memory.
    always_comb begin
        trk_d        = trk_q;
        trk_d.in_ex  = store_arm && !stall;
        trk_d.in_mem = trk_q.in_ex;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trk_q <= '0;
        end else begin
            trk_q <= trk_d;
        end
    end

    always_comb begin
        fwd_sel_a        = sel_vec[0];
        fwd_sel_b        = sel_vec[1];
        freeze_front     = stall;
        bubble_ex        = stall;
        mem_store_bypass = trk_q.in_mem;
    end

    p_store_no_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (store_arm && !hit_ex_vec[0] && !(dec_reads_hilo && muldiv_busy)) |-> !freeze_front);

    p_bypass_origin_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_store_bypass |-> $past(store_arm && !stall, 2));

    p_frozen_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (store_arm && stall) |=> !trk_q.in_ex);

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !mem_store_bypass);

endmodule

// File: tb/test_operand_hazard_unit.sv
module test_operand_hazard_unit;

    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          dec_valid, dec_is_store, dec_reads_hilo, muldiv_busy;
    logic [AW-1:0] dec_src_a, dec_src_b, ex_dst, mem_dst, wb_dst;
    logic          ex_valid, ex_wen, ex_is_load;
    logic          mem_valid, mem_wen, wb_valid, wb_wen;
    logic [1:0]    sel_a, sel_b, nw_sel_a, nw_sel_b;
    logic          st_byp, freeze, bubble, nw_st_byp, nw_freeze, nw_bubble;

    int n_checks = 0;
    int n_fail   = 0;
    bit exp_ex_q  = 1'b0;
    bit exp_mem_q = 1'b0;
    bit done      = 1'b0;

    always #10 clk = ~clk;

    operand_hazard_unit #(.REG_ADDR_W(AW), .WB_BYPASS(1'b1)) i_operand_hazard_unit (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src_a(dec_src_a),
        .dec_src_b(dec_src_b), .dec_is_store(dec_is_store), .dec_reads_hilo(dec_reads_hilo),
        .ex_valid(ex_valid), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_valid(mem_valid), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_wen(wb_wen), .muldiv_busy(muldiv_busy),
        .fwd_sel_a(sel_a), .fwd_sel_b(sel_b), .mem_store_bypass(st_byp),
        .freeze_front(freeze), .bubble_ex(bubble));

    operand_hazard_unit #(.REG_ADDR_W(AW), .WB_BYPASS(1'b0)) i_operand_hazard_unit_nowb (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_src_a(dec_src_a),
        .dec_src_b(dec_src_b), .dec_is_store(dec_is_store), .dec_reads_hilo(dec_reads_hilo),
        .ex_valid(ex_valid), .ex_dst(ex_dst), .ex_wen(ex_wen), .ex_is_load(ex_is_load),
        .mem_valid(mem_valid), .mem_dst(mem_dst), .mem_wen(mem_wen),
        .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_wen(wb_wen), .muldiv_busy(muldiv_busy),
        .fwd_sel_a(nw_sel_a), .fwd_sel_b(nw_sel_b), .mem_store_bypass(nw_st_byp),
        .freeze_front(nw_freeze), .bubble_ex(nw_bubble));

    // Expected select per R1..R4 and R10
    function automatic logic [1:0] exp_sel(logic [AW-1:0] s, bit wb_ok);
        if (s == '0) return 2'b00;
        if (ex_valid && ex_wen && ex_dst == s) return 2'b01;
        if (mem_valid && mem_wen && mem_dst == s) return 2'b10;
        if (wb_ok && wb_valid && wb_wen && wb_dst == s) return 2'b11;
        return 2'b00;
    endfunction

    function automatic bit ex_load_hit(logic [AW-1:0] s);
        return (s != '0) && ex_valid && ex_wen && ex_is_load && ex_dst == s;
    endfunction

    // Expected stall per R5, R8, R9
    function automatic bit exp_stall();
        bit lu;
        lu = ex_load_hit(dec_src_a) || (ex_load_hit(dec_src_b) && !dec_is_store);
        return dec_valid && (lu || (dec_reads_hilo && muldiv_busy));
    endfunction

    function automatic bit exp_arm();
        return dec_valid && dec_is_store && ex_load_hit(dec_src_b);
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic set_idle();
        dec_valid = 0; dec_src_a = 0; dec_src_b = 0; dec_is_store = 0; dec_reads_hilo = 0;
        ex_valid = 0; ex_dst = 0; ex_wen = 0; ex_is_load = 0;
        mem_valid = 0; mem_dst = 0; mem_wen = 0;
        wb_valid = 0; wb_dst = 0; wb_wen = 0; muldiv_busy = 0;
    endtask

    // Check all outputs between edges, then advance the bench model one edge.
    task automatic step(string tag);
        bit nx_ex, nx_mem;
        @(negedge clk);
        #2;
        chk(tag, "fwd_sel_a", sel_a, exp_sel(dec_src_a, 1'b1));
        chk(tag, "fwd_sel_b", sel_b, exp_sel(dec_src_b, 1'b1));
        chk(tag, "freeze_front", freeze, exp_stall());
        chk(tag, "bubble_ex", bubble, exp_stall());
        chk(tag, "mem_store_bypass", st_byp, exp_mem_q);
        chk(tag, "nowb fwd_sel_a", nw_sel_a, exp_sel(dec_src_a, 1'b0));
        chk(tag, "nowb fwd_sel_b", nw_sel_b, exp_sel(dec_src_b, 1'b0));
        nx_ex  = rst_n && exp_arm() && !exp_stall();
        nx_mem = rst_n && exp_ex_q;
        @(posedge clk);
        #1;
        exp_ex_q  = nx_ex;
        exp_mem_q = nx_mem;
    endtask

    initial begin
        #200000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd2718);
        set_idle();
        // R11: reset holds the bypass low; a store-bypass pattern is applied meanwhile
        dec_valid = 1; dec_is_store = 1; dec_src_b = 5'd4;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dst = 5'd4;
        step("R11");
        step("R11");
        set_idle();
        rst_n = 1'b1;
        step("R11");

        // R3: register 0 as source and destination everywhere
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dst = 0;
        mem_valid = 1; mem_wen = 1; wb_valid = 1; wb_wen = 1;
        dec_valid = 1; dec_src_a = 0; dec_src_b = 0;
        step("R3");

        // R2: all three match -> execute; then memory; then write-back
        set_idle();
        dec_valid = 1; dec_src_a = 5'd7; dec_src_b = 5'd9;
        ex_valid = 1; ex_wen = 1; ex_dst = 5'd7;
        mem_valid = 1; mem_wen = 1; mem_dst = 5'd7;
        wb_valid = 1; wb_wen = 1; wb_dst = 5'd7;
        step("R2");
        ex_dst = 5'd3;
        step("R2");
        mem_dst = 5'd3;
        step("R2");
        // R10: write-back-only match on the instance without that path
        step("R10");
        // R1: write enable low removes a match
        wb_wen = 0;
        step("R1");

        // R4: invalid execute entry ignored, memory supplies
        set_idle();
        dec_valid = 1; dec_src_a = 5'd12;
        ex_valid = 0; ex_wen = 1; ex_is_load = 1; ex_dst = 5'd12;
        mem_valid = 1; mem_wen = 1; mem_dst = 5'd12;
        step("R4");

        // R5: load-use on B of a non-store, then on A
        set_idle();
        dec_valid = 1; dec_src_b = 5'd6;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dst = 5'd6;
        step("R5");
        dec_src_a = 5'd6; dec_src_b = 5'd1;
        step("R5");

        // R9: same load-use with decode not valid
        dec_valid = 0;
        step("R9");

        // R6: store data from a load: no stall, bypass two edges later
        set_idle();
        dec_valid = 1; dec_is_store = 1; dec_src_a = 5'd2; dec_src_b = 5'd8;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dst = 5'd8;
        step("R6");
        set_idle();
        step("R6");
        step("R6");
        step("R6");

        // R7: store address also hits the load -> stall, no bypass later
        dec_valid = 1; dec_is_store = 1; dec_src_a = 5'd8; dec_src_b = 5'd8;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dst = 5'd8;
        step("R7");
        set_idle();
        step("R7");
        step("R7");

        // R8: result-register read waits on busy, proceeds when idle
        dec_valid = 1; dec_reads_hilo = 1; muldiv_busy = 1;
        step("R8");
        muldiv_busy = 0;
        step("R8");
        // R7: busy read stall also suppresses a store bypass
        dec_is_store = 1; dec_src_b = 5'd5; muldiv_busy = 1;
        ex_valid = 1; ex_wen = 1; ex_is_load = 1; ex_dst = 5'd5;
        step("R7");
        set_idle();
        step("R7");
        step("R7");

        // R1: random vectors over a small register space
        for (int i = 0; i < 600; i++) begin
            dec_valid      = ($urandom % 8) != 0;
            dec_src_a      = AW'($urandom % 4);
            dec_src_b      = AW'($urandom % 4);
            dec_is_store   = ($urandom % 3) == 0;
            dec_reads_hilo = ($urandom % 6) == 0;
            muldiv_busy    = $urandom % 2;
            ex_valid       = ($urandom % 4) != 0;
            ex_dst         = AW'($urandom % 4);
            ex_wen         = ($urandom % 4) != 0;
            ex_is_load     = $urandom % 2;
            mem_valid      = ($urandom % 4) != 0;
            mem_dst        = AW'($urandom % 4);
            mem_wen        = $urandom % 2;
            wb_valid       = ($urandom % 4) != 0;
            wb_dst         = AW'($urandom % 4);
            wb_wen         = $urandom % 2;
            step("R1");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule